// File: doc/BRIEF.md
# Raster beam timing generator

This block keeps track of where the video beam is. The video side runs on its own tick at 11/7 of the system clock, and a per-cycle system-tick enable drives it. Each enabled cycle adds 11 to a small remainder register. One video tick is produced for every whole 7 in the sum, and what is left over is carried into the next cycle. So an enabled cycle advances the beam by one or two ticks.

The tick position counts across a line and the line position counts down a frame. The line and frame totals come from parameters, and a PAL/NTSC select chooses between the two sets. The two totals are each 3413 ticks by 263 lines and 3406 ticks by 314 lines.

Display-window start and end inputs are clamped to the selected totals and then compared with the beam position to give the hblank and vblank flags. The block raises a one-cycle interrupt pulse when vblank begins and a one-cycle event pulse for an external counter when hblank begins. It also tracks the interlace field, derives an odd-line status bit from a start-Y value, and returns the dot-clock divider chosen by a 3-bit resolution index.

Top module: `beam_timing_gen`

## Requirements
- R1: On a clock with `sys_tick_en` high, the beam advances by floor((r + 11) / 7) ticks, where r is the carried remainder (0 after reset). r then becomes (r + 11) mod 7. On a clock with `sys_tick_en` low, neither `tick_pos` nor `line_pos` changes.
- R2: `tick_pos` counts from 0 to the line total minus 1 and then wraps to 0, and each wrap adds one line. The line total is `NTSC_HTOTAL` when `pal_sel` is 0 and `PAL_HTOTAL` when it is 1. A two-tick advance that crosses the end of a line lands on tick 1 of the next line.
- R3: `line_pos` counts from 0 to the frame total minus 1 and then wraps to 0. The frame total is `NTSC_VTOTAL` or `PAL_VTOTAL`, chosen by `pal_sel`.
- R4: `hblank` is 1 when `tick_pos` < min(`h_disp_start`, line total) or `tick_pos` >= min(`h_disp_end`, line total). It is 0 otherwise.
- R5: `vblank` is 1 when `line_pos` < min(`v_disp_start`, frame total) or `line_pos` >= min(`v_disp_end`, frame total). It is 0 otherwise.
- R6: `vblank_irq` is high for exactly one cycle: the first cycle in which `vblank` is 1 after a cycle in which it was 0.
- R7: `hblank_evt` is high for exactly one cycle: the first cycle in which `hblank` is 1 after a cycle in which it was 0.
- R8: When `line_pos` wraps to 0, `field` inverts if `interlace_en` is 1 and is cleared if `interlace_en` is 0. At any other time `field` holds its value.
- R9: When `vres_480` and `interlace_en` are both 1, `odd_line` is bit 0 of (`start_y` + (`field` AND NOT `vblank`)). In all other cases it is bit 0 of (`start_y` + `line_pos`).
- R10: `dot_div` is selected by the index {`hres_wide`, `hres_base`}. Index 0 gives 10, 1 gives 8, 2 gives 5, 3 gives 4, and indices 4 to 7 give 7.
- R11: While `rst_n` is low, `tick_pos`, `line_pos` and `field` are 0, `hblank` and `vblank` are 1, and both pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_tick_en | input | 1 | One system tick elapses this cycle |
| pal_sel | input | 1 | 1 selects the PAL totals, 0 selects the NTSC totals |
| h_disp_start | input | HW | Horizontal display window start, in ticks |
| h_disp_end | input | HW | Horizontal display window end, in ticks |
| v_disp_start | input | VW | Vertical display window start, in lines |
| v_disp_end | input | VW | Vertical display window end, in lines |
| hres_base | input | 2 | Low two bits of the resolution index |
| hres_wide | input | 1 | Bit 2 of the resolution index |
| vres_480 | input | 1 | 480-line vertical mode |
| interlace_en | input | 1 | Interlaced output enable |
| start_y | input | YW | Display start row |
| tick_pos | output | HW | Tick within the current line |
| line_pos | output | VW | Current line |
| hblank | output | 1 | Horizontal blanking flag |
| vblank | output | 1 | Vertical blanking flag |
| vblank_irq | output | 1 | One-cycle pulse when vblank begins |
| hblank_evt | output | 1 | One-cycle pulse when hblank begins |
| field | output | 1 | Interlace field |
| odd_line | output | 1 | Odd-line status bit |
| dot_div | output | 4 | Selected dot-clock divider |

## Verification
The awkward coincidence is a two-tick advance that crosses the end of a line in the same cycle that the line counter wraps the frame. In that one cycle the tick lands on 1, the line steps, the field updates, and the hblank and vblank flags, together with their pulses, are all re-evaluated. The bench provokes this by sweeping many window and mode settings, each with a dense and a sparse enable pattern, under small totals, so that the 11/7 remainder walks through every phase at every line end. An arithmetic model in the bench advances one tick at a time, and each cycle it judges every output against that model.

// File: rtl/beam_pkg.sv
package beam_pkg;

  localparam int unsigned CW = 16;
  typedef logic [CW-1:0] cnt_t;

  // limit a programmed window edge to the active total
  function automatic cnt_t clamp_to(input cnt_t v, input cnt_t lim);
    return (v > lim) ? lim : v;
  endfunction

  // blanking: position before the window opens or at/after it closes
  function automatic logic outside_window(input cnt_t pos, input cnt_t lo, input cnt_t hi);
    return (pos < lo) || (pos >= hi);
  endfunction

  function automatic logic [3:0] dot_divider(input logic [2:0] idx);
    logic [3:0] d;
    case (idx)
      3'd0:    d = 4'd10;
      3'd1:    d = 4'd8;
      3'd2:    d = 4'd5;
      3'd3:    d = 4'd4;
      default: d = 4'd7;
    endcase
    return d;
  endfunction

  function automatic logic odd_line_bit(input logic mode_480i, input cnt_t sy,
                                        input cnt_t line, input logic fld, input logic vb);
    cnt_t s;
    s = mode_480i ? (sy + cnt_t'(fld & ~vb)) : (sy + line);
    return s[0];
  endfunction

endpackage

// File: rtl/beam_tick_frac.sv
module beam_tick_frac #(
  parameter int MUL = 11,
  parameter int DIV = 7,
  parameter int AVW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  output logic [AVW-1:0] adv
);
  localparam int RW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int SW = $clog2(DIV + MUL);

  logic [RW-1:0] rem_q, rem_d;
  logic [SW-1:0] sum;

  always_comb begin
    sum   = SW'(rem_q) + SW'(MUL);
    adv   = '0;
    rem_d = rem_q;
    if (en) begin
      adv   = AVW'(sum / SW'(DIV));
      rem_d = RW'(sum % SW'(DIV));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end
endmodule

// File: rtl/beam_hcount.sv
module beam_hcount #(
  parameter int W   = 12,
  parameter int AVW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AVW-1:0] adv,
  input  logic [W-1:0]   total,
  output logic [W-1:0]   tick,
  output logic [W-1:0]   tick_next,
  output logic           line_step
);
  logic [W:0] sum;

  always_comb begin
    sum       = {1'b0, tick} + (W+1)'(adv);
    tick_next = tick;
    line_step = 1'b0;
    if (adv != '0) begin
      if (tick >= total) begin
        tick_next = '0;
        line_step = 1'b1;
      end else if (sum >= {1'b0, total}) begin
        tick_next = W'(sum - {1'b0, total});
        line_step = 1'b1;
      end else begin
        tick_next = sum[W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tick <= '0;
    else        tick <= tick_next;
  end
endmodule

// File: rtl/beam_vcount.sv
module beam_vcount #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] total,
  input  logic         interlace_en,
  output logic [W-1:0] line,
  output logic [W-1:0] line_next,
  output logic         field,
  output logic         frame_wrap
);
  logic field_d;

  always_comb begin
    line_next  = line;
    frame_wrap = 1'b0;
    if (step) begin
      if (line >= total - W'(1)) begin
        line_next  = '0;
        frame_wrap = 1'b1;
      end else begin
        line_next = line + W'(1);
      end
    end
    field_d = frame_wrap ? (interlace_en & ~field) : field;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line  <= '0;
      field <= 1'b0;
    end else begin
      line  <= line_next;
      field <= field_d;
    end
  end
endmodule

// File: rtl/beam_timing_gen.sv
module beam_timing_gen #(
  parameter int NTSC_HTOTAL = 3413,
  parameter int NTSC_VTOTAL = 263,
  parameter int PAL_HTOTAL  = 3406,
  parameter int PAL_VTOTAL  = 314,
  parameter int TICK_MUL    = 11,
  parameter int TICK_DIV    = 7,
  parameter int YW          = 10,
  localparam int HMAX = (NTSC_HTOTAL > PAL_HTOTAL) ? NTSC_HTOTAL : PAL_HTOTAL,
  localparam int VMAX = (NTSC_VTOTAL > PAL_VTOTAL) ? NTSC_VTOTAL : PAL_VTOTAL,
  localparam int HW   = $clog2(HMAX + 1),
  localparam int VW   = $clog2(VMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_tick_en,
  input  logic          pal_sel,
  input  logic [HW-1:0] h_disp_start,
  input  logic [HW-1:0] h_disp_end,
  input  logic [VW-1:0] v_disp_start,
  input  logic [VW-1:0] v_disp_end,
  input  logic [1:0]    hres_base,
  input  logic          hres_wide,
  input  logic          vres_480,
  input  logic          interlace_en,
  input  logic [YW-1:0] start_y,
  output logic [HW-1:0] tick_pos,
  output logic [VW-1:0] line_pos,
  output logic          hblank,
  output logic          vblank,
  output logic          vblank_irq,
  output logic          hblank_evt,
  output logic          field,
  output logic          odd_line,
  output logic [3:0]    dot_div
);
  import beam_pkg::*;

  localparam int ADV_MAX = (TICK_DIV - 1 + TICK_MUL) / TICK_DIV;
  localparam int AVW     = $clog2(ADV_MAX + 1);

  logic [HW-1:0]  h_total;
  logic [VW-1:0]  v_total;
  logic [AVW-1:0] adv;
  logic [HW-1:0]  tick_d;
  logic [VW-1:0]  line_d;
  logic           line_step;
  logic           frame_wrap;
  cnt_t           h_lo, h_hi, v_lo, v_hi;
  logic           hb_d, vb_d;

  assign h_total = pal_sel ? HW'(PAL_HTOTAL) : HW'(NTSC_HTOTAL);
  assign v_total = pal_sel ? VW'(PAL_VTOTAL) : VW'(NTSC_VTOTAL);

  assign h_lo = clamp_to(cnt_t'(h_disp_start), cnt_t'(h_total));
  assign h_hi = clamp_to(cnt_t'(h_disp_end),   cnt_t'(h_total));
  assign v_lo = clamp_to(cnt_t'(v_disp_start), cnt_t'(v_total));
  assign v_hi = clamp_to(cnt_t'(v_disp_end),   cnt_t'(v_total));

  beam_tick_frac #(.MUL(TICK_MUL), .DIV(TICK_DIV), .AVW(AVW)) u_frac (
    .clk(clk), .rst_n(rst_n), .en(sys_tick_en), .adv(adv)
  );

  beam_hcount #(.W(HW), .AVW(AVW)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .adv(adv), .total(h_total),
    .tick(tick_pos), .tick_next(tick_d), .line_step(line_step)
  );

  beam_vcount #(.W(VW)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .step(line_step), .total(v_total),
    .interlace_en(interlace_en), .line(line_pos), .line_next(line_d),
    .field(field), .frame_wrap(frame_wrap)
  );

  assign hb_d = outside_window(cnt_t'(tick_d), h_lo, h_hi);
  assign vb_d = outside_window(cnt_t'(line_d), v_lo, v_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hblank     <= 1'b1;
      vblank     <= 1'b1;
      hblank_evt <= 1'b0;
      vblank_irq <= 1'b0;
    end else begin
      hblank     <= hb_d;
      vblank     <= vb_d;
      hblank_evt <= hb_d & ~hblank;
      vblank_irq <= vb_d & ~vblank;
    end
  end

  assign odd_line = odd_line_bit(vres_480 & interlace_en, cnt_t'(start_y),
                                 cnt_t'(line_pos), field, vblank);
  assign dot_div  = dot_divider({hres_wide, hres_base});
endmodule

// File: rtl/beam_timing_chk.sv
module beam_timing_chk #(
  parameter int HW  = 12,
  parameter int VW  = 9,
  parameter int AVW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sys_tick_en,
  input logic           pal_sel,
  input logic           interlace_en,
  input logic [AVW-1:0] adv,
  input logic [HW-1:0]  h_total,
  input logic [HW-1:0]  tick_pos,
  input logic [VW-1:0]  line_pos,
  input logic           frame_wrap,
  input logic           field,
  input logic           hblank,
  input logic           vblank,
  input logic           vblank_irq,
  input logic           hblank_evt,
  input logic [3:0]     dot_div
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_tick_en |=> $stable(tick_pos) && $stable(line_pos)); // R1

  AST_ADV_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_tick_en |-> adv != '0); // R1

  AST_TICK_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_pos < h_total) |=> (pal_sel != $past(pal_sel)) || (tick_pos < h_total)); // R2

  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(field)); // R8

  AST_FIELD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap && !interlace_en |=> !field); // R8

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq |=> !vblank_irq); // R6

  AST_IRQ_IN_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq |-> vblank); // R6

  AST_HEVT_IN_HBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_evt |-> hblank); // R7

  AST_HEVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_evt |=> !hblank_evt); // R7

  AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_div == 4'd4) || (dot_div == 4'd5) || (dot_div == 4'd7) ||
    (dot_div == 4'd8) || (dot_div == 4'd10)); // R10
endmodule

bind beam_timing_gen beam_timing_chk #(.HW(HW), .VW(VW), .AVW(AVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_tick_en(sys_tick_en), .pal_sel(pal_sel),
  .interlace_en(interlace_en), .adv(adv), .h_total(h_total),
  .tick_pos(tick_pos), .line_pos(line_pos), .frame_wrap(frame_wrap),
  .field(field), .hblank(hblank), .vblank(vblank), .vblank_irq(vblank_irq),
  .hblank_evt(hblank_evt), .dot_div(dot_div)
);

// File: tb/tb_beam_timing_gen.sv
`timescale 1ns/1ps
module tb_beam_timing_gen;
  localparam int NH = 13, NV = 7, PH = 11, PV = 9;
  localparam int HW = 4, VW = 4, YW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sys_tick_en = 1'b0;
  logic          pal_sel = 1'b0;
  logic [HW-1:0] h_disp_start = '0, h_disp_end = '0;
  logic [VW-1:0] v_disp_start = '0, v_disp_end = '0;
  logic [1:0]    hres_base = '0;
  logic          hres_wide = 1'b0;
  logic          vres_480 = 1'b0;
  logic          interlace_en = 1'b0;
  logic [YW-1:0] start_y = '0;
  logic [HW-1:0] tick_pos;
  logic [VW-1:0] line_pos;
  logic          hblank, vblank, vblank_irq, hblank_evt, field, odd_line;
  logic [3:0]    dot_div;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // model state
  int m_rem, m_tick, m_line, m_field, m_hb, m_vb, e_hevt, e_irq;

  always #10 clk = ~clk;

  beam_timing_gen #(.NTSC_HTOTAL(NH), .NTSC_VTOTAL(NV), .PAL_HTOTAL(PH),
                    .PAL_VTOTAL(PV), .YW(YW)) dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int ht(); return pal_sel ? PH : NH; endfunction
  function automatic int vt(); return pal_sel ? PV : NV; endfunction

  task automatic model_one_tick();
    m_tick = m_tick + 1;
    if (m_tick == ht()) begin
      m_tick = 0;
      m_line = m_line + 1;
      if (m_line == vt()) begin
        m_line  = 0;
        m_field = interlace_en ? (1 - m_field) : 0;   // R8
      end
    end
  endtask

  task automatic model_clock(input logic en);
    int s, n, hb_new, vb_new;
    if (en) begin
      s = m_rem + 11; n = 0;
      while (s >= 7) begin s = s - 7; n++; end
      m_rem = s;
      repeat (n) model_one_tick();
    end
    hb_new = (m_tick < min2(h_disp_start, ht())) || (m_tick >= min2(h_disp_end, ht()));
    vb_new = (m_line < min2(v_disp_start, vt())) || (m_line >= min2(v_disp_end, vt()));
    e_hevt = hb_new && !m_hb;
    e_irq  = vb_new && !m_vb;
    m_hb = hb_new;
    m_vb = vb_new;
  endtask

  task automatic compare_all();
    int e_odd;
    if (vres_480 && interlace_en) e_odd = (start_y + (m_field & (1 - m_vb))) % 2;
    else                          e_odd = (start_y + m_line) % 2;
    chk("R1 R2", "tick_pos", tick_pos, m_tick);
    chk("R3", "line_pos", line_pos, m_line);
    chk("R4", "hblank", hblank, m_hb);
    chk("R5", "vblank", vblank, m_vb);
    chk("R6", "vblank_irq", vblank_irq, e_irq);
    chk("R7", "hblank_evt", hblank_evt, e_hevt);
    chk("R8", "field", field, m_field);
    chk("R9", "odd_line", odd_line, e_odd);
  endtask

  task automatic step(input logic en);
    sys_tick_en = en;
    @(posedge clk);
    @(negedge clk);
    model_clock(en);
    compare_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sys_tick_en = 1'b0;
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11", "tick_pos", tick_pos, 0);
    chk("R11", "line_pos", line_pos, 0);
    chk("R11", "field", field, 0);
    chk("R11", "hblank", hblank, 1);
    chk("R11", "vblank", vblank, 1);
    chk("R11", "vblank_irq", vblank_irq, 0);
    chk("R11", "hblank_evt", hblank_evt, 0);
    m_rem = 0; m_tick = 0; m_line = 0; m_field = 0; m_hb = 1; m_vb = 1;
    rst_n = 1'b1;
  endtask

  initial begin
    logic [7:0] lfsr;
    @(negedge clk);
    // R10: every divider index
    for (int i = 0; i < 8; i++) begin
      int e;
      {hres_wide, hres_base} = 3'(i);
      #1;
      e = (i >= 4) ? 7 : (i == 0) ? 10 : (i == 1) ? 8 : (i == 2) ? 5 : 4;
      chk("R10", "dot_div", dot_div, e);
    end
    lfsr = 8'hA5;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      pal_sel      = c[0];
      interlace_en = c[1];
      vres_480     = c[2];
      h_disp_start = HW'(c % 5);
      h_disp_end   = (c % 3 == 0) ? HW'(15) : HW'(8 + (c % 4));
      v_disp_start = VW'(c % 4);
      v_disp_end   = (c % 3 == 1) ? VW'(15) : VW'(4 + (c % 3));
      start_y      = YW'(c);
      do_reset();
      for (int k = 0; k < 260; k++) begin
        logic en;
        en   = (c < 8) ? 1'b1 : (lfsr[0] | lfsr[3]);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        step(en);
      end
      // R1: idle cycles leave the beam unchanged
      repeat (5) step(1'b0);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule